// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt and Wake Unit

This block watches a bank of general-purpose input pins and turns selected transitions into pending events. Each pin runs through a two-stage synchronizer. A transition is found by comparing the synchronized level with the level one clock earlier. There are four per-pin enable registers:

- an interrupt enable for rising edges;
- an interrupt enable for falling edges;
- a wake enable for rising edges;
- a wake enable for falling edges.

An enabled transition latches a sticky pending bit at the pin's own bit position. The pending bits drive a combined interrupt line. They stay set until software writes ones to an acknowledge address.

Pending bits whose edge was wake-enabled also drive a separate combined wake line. The block also reports the lowest-numbered pending pin, so a service loop can take pins in ascending order until nothing is left. Detection works on edges only; a steady level never raises an event.

Top module: `gpio_edge_irq`

## Requirements
- R1: Bit i of the rising interrupt enable (address 0) makes a 0-to-1 change on pin i set pending bit i. Bit i of the falling interrupt enable (address 1) does the same for a 1-to-0 change. A pin may have either edge, both edges or neither enabled, and a disabled edge sets nothing.
- R2: Bit i of the rising wake enable (address 2) and of the falling wake enable (address 3) also set pending bit i on the matching edge, independently of the interrupt enables.
- R3: Reading address 4 returns the pending bits. Writing address 5 clears each pending bit whose data bit is 1 and leaves bits written 0 untouched. Writes to address 4 change nothing, and reads of address 5 return zero.
- R4: Detection is edge-only: a pin held at a constant level sets no pending bit, however long it is held.
- R5: `irq_o` is high exactly while at least one pending bit is set.
- R6: `wake_o` is high while at least one pin whose latching edge was wake-enabled is still pending. It drops when those bits are acknowledged, and an edge enabled only for interrupts does not raise it.
- R7: While any bit is pending, `first_vld_o` is 1 and `first_idx_o` gives the lowest-numbered pending pin.
- R8: A pin change presented before clock edge k first shows in the pending bits, `irq_o` and `wake_o` after edge k+2, and not earlier.
- R9: When a new enabled edge and an acknowledge hit the same pin in the same cycle, the pending bit stays set.
- R10: After reset, all four enable registers and the pending bits are zero, and `irq_o`, `wake_o` and `first_vld_o` are low.
- R11: Addresses 0 to 3 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address (0-3 enables, 5 acknowledge) |
| wr_data | input | NPINS | Write data, one bit per pin |
| rd_addr | input | AW | Read address |
| rd_data | output | NPINS | Read data for rd_addr |
| irq_o | output | 1 | Combined interrupt |
| wake_o | output | 1 | Combined wake request |
| first_vld_o | output | 1 | Some pin is pending |
| first_idx_o | output | $clog2(NPINS) | Lowest pending pin number |

## Verification
The hardest case to reach from the ports is an acknowledge that lands on the very cycle in which a fresh edge on the same pin is being latched. The test has to set a pin pending first, then change its level, and then place the acknowledge write exactly two clocks later. The bench reaches it with a directed sequence timed from the three-register latency. Random pin toggles mixed with random acknowledges then exercise further coincidences, all compared cycle by cycle against a bench model.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NPINS = 32,
  parameter int AW    = 3,
  localparam int IW   = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [NPINS-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [NPINS-1:0] rd_data,
  output logic             irq_o,
  output logic             wake_o,
  output logic             first_vld_o,
  output logic [IW-1:0]    first_idx_o
);
  localparam logic [AW-1:0] A_RISE  = AW'(0);
  localparam logic [AW-1:0] A_FALL  = AW'(1);
  localparam logic [AW-1:0] A_WRISE = AW'(2);
  localparam logic [AW-1:0] A_WFALL = AW'(3);
  localparam logic [AW-1:0] A_STAT  = AW'(4);
  localparam logic [AW-1:0] A_ACK   = AW'(5);

  logic [NPINS-1:0] sync1, sync2, prev;
  logic [NPINS-1:0] rise_en, fall_en, wrise_en, wfall_en;
  logic [NPINS-1:0] pend, wpend;
  logic [NPINS-1:0] rise_ev, fall_ev, irq_hit, wake_hit, ack;

  assign rise_ev  = sync2 & ~prev;
  assign fall_ev  = ~sync2 & prev;
  assign irq_hit  = (rise_ev & rise_en) | (fall_ev & fall_en);
  assign wake_hit = (rise_ev & wrise_en) | (fall_ev & wfall_en);
  assign ack      = (wr_en && wr_addr == A_ACK) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1    <= '0;
      sync2    <= '0;
      prev     <= '0;
      rise_en  <= '0;
      fall_en  <= '0;
      wrise_en <= '0;
      wfall_en <= '0;
      pend     <= '0;
      wpend    <= '0;
    end else begin
      sync1 <= pin_i;
      sync2 <= sync1;
      prev  <= sync2;
      pend  <= (pend & ~ack) | irq_hit | wake_hit;
      wpend <= (wpend & ~ack) | wake_hit;
      if (wr_en) begin
        case (wr_addr)
          A_RISE:  rise_en  <= wr_data;
          A_FALL:  fall_en  <= wr_data;
          A_WRISE: wrise_en <= wr_data;
          A_WFALL: wfall_en <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_RISE:  rd_data = rise_en;
      A_FALL:  rd_data = fall_en;
      A_WRISE: rd_data = wrise_en;
      A_WFALL: rd_data = wfall_en;
      A_STAT:  rd_data = pend;
      default: rd_data = '0;
    endcase
  end

  always_comb begin
    first_idx_o = '0;
    for (int i = NPINS - 1; i >= 0; i--)
      if (pend[i]) first_idx_o = IW'(i);
  end

  assign first_vld_o = |pend;
  assign irq_o       = |pend;
  assign wake_o      = |wpend;
endmodule

module gpio_edge_irq_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 3,
  localparam int IW   = $clog2(NPINS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic             irq_o,
  input logic             wake_o,
  input logic             first_vld_o,
  input logic [IW-1:0]    first_idx_o,
  input logic [NPINS-1:0] pend,
  input logic [NPINS-1:0] rise_en,
  input logic [NPINS-1:0] fall_en,
  input logic [NPINS-1:0] wrise_en,
  input logic [NPINS-1:0] wfall_en
);
  logic ack_wr;
  logic [NPINS-1:0] below;
  logic no_en;
  assign ack_wr = wr_en && (wr_addr == AW'(5));
  assign below  = ({{(NPINS-1){1'b0}}, 1'b1} << first_idx_o) - 1'b1;
  assign no_en  = (rise_en | fall_en | wrise_en | wfall_en) == '0;

  a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_wr) |=> irq_o);
  a_r6_wake_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o && !ack_wr) |=> wake_o);
  a_r6_wake_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> irq_o);
  a_r7_lowest_pending: assert property (@(posedge clk) disable iff (!rst_n)
    first_vld_o |-> (pend[first_idx_o] && ((pend & below) == '0)));
  a_r7_vld_tracks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    first_vld_o == irq_o);
  a_r1_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (no_en && !irq_o) |=> !irq_o);
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .irq_o(irq_o), .wake_o(wake_o), .first_vld_o(first_vld_o),
  .first_idx_o(first_idx_o), .pend(pend), .rise_en(rise_en),
  .fall_en(fall_en), .wrise_en(wrise_en), .wfall_en(wfall_en)
);

// File: tb/gpio_edge_irq_tb.sv
`timescale 1ns/1ps
module gpio_edge_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_i = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = 3'd4;
  logic [31:0] rd_data;
  logic        irq_o, wake_o, first_vld_o;
  logic [4:0]  first_idx_o;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] m_s1, m_s2, m_s3, m_ren, m_fen, m_wr, m_wf, m_pend, m_wp;
  logic [31:0] cur_pins = '0;

  always #2 clk = ~clk;

  gpio_edge_irq u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o),
    .wake_o(wake_o), .first_vld_o(first_vld_o), .first_idx_o(first_idx_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_ren;
      3'd1: return m_fen;
      3'd2: return m_wr;
      3'd3: return m_wf;
      3'd4: return m_pend;
      default: return '0;
    endcase
  endfunction

  function automatic logic [4:0] lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 5'(i);
    return 5'd0;
  endfunction

  task automatic model_reset();
    {m_s1, m_s2, m_s3, m_ren, m_fen, m_wr, m_wf, m_pend, m_wp} = '0;
  endtask

  task automatic step(input logic [31:0] pins, input logic we, input logic [2:0] wa,
                      input logic [31:0] wd, input logic [2:0] ra);
    logic [31:0] rise, fall, hit, wh, ak;
    pin_i = pins; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    rise = m_s2 & ~m_s3;
    fall = ~m_s2 & m_s3;
    hit  = (rise & m_ren) | (fall & m_fen);
    wh   = (rise & m_wr) | (fall & m_wf);
    ak   = (we && wa == 3'd5) ? wd : '0;
    m_pend = (m_pend & ~ak) | hit | wh;
    m_wp   = (m_wp & ~ak) | wh;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = pins;
    if (we) begin
      case (wa)
        3'd0: m_ren = wd;
        3'd1: m_fen = wd;
        3'd2: m_wr  = wd;
        3'd3: m_wf  = wd;
        default: ;
      endcase
    end
    @(negedge clk);
    chk(ra < 3'd4 ? "R11" : "R3", rd_data, exp_rd(ra));
    chk("R5", 32'(irq_o), 32'(m_pend != 0));
    chk("R6", 32'(wake_o), 32'(m_wp != 0));
    chk("R7", 32'(first_vld_o), 32'(m_pend != 0));
    if (m_pend != 0) chk("R7", 32'(first_idx_o), 32'(lowest(m_pend)));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(cur_pins, 1'b0, 3'd0, '0, 3'd4);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    step(cur_pins, 1'b1, a, d, 3'd4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    for (int a = 0; a < 6; a++) begin
      step(cur_pins, 1'b0, 3'd0, '0, 3'(a));
      chk("R10", rd_data, '0);
    end
    chk("R10", {29'd0, irq_o, wake_o, first_vld_o}, '0);

    // R11 / R1 setup
    wreg(3'd0, 32'h0000_0001);
    wreg(3'd1, 32'h8000_0000);
    step(cur_pins, 1'b0, 3'd0, '0, 3'd0); chk("R11", rd_data, 32'h0000_0001);
    step(cur_pins, 1'b0, 3'd0, '0, 3'd1); chk("R11", rd_data, 32'h8000_0000);

    // R8: latency of three edges
    cur_pins[0] = 1'b1;
    idle(1); chk("R8", rd_data, '0);
    idle(1); chk("R8", rd_data, '0); chk("R8", 32'(irq_o), 0);
    idle(1); chk("R8", rd_data, 32'h1); chk("R8", 32'(irq_o), 1);

    // R4: steady level after ack does not re-pend
    wreg(3'd5, 32'h1);
    idle(20); chk("R4", rd_data, '0);
    // R1: falling edge on pin 0 not enabled
    cur_pins[0] = 1'b0;
    idle(6); chk("R1", rd_data, '0);

    // R1: pin 31 only falling enabled
    cur_pins[31] = 1'b1; idle(6); chk("R1", rd_data, '0);
    cur_pins[31] = 1'b0; idle(6); chk("R1", rd_data, 32'h8000_0000);
    chk("R7", 32'(first_idx_o), 31);
    cur_pins[0] = 1'b1; idle(6); chk("R7", 32'(first_idx_o), 0);
    wreg(3'd5, 32'h1); chk("R7", 32'(first_idx_o), 31);
    wreg(3'd5, 32'h0); chk("R3", rd_data, 32'h8000_0000);
    wreg(3'd4, 32'h0); chk("R3", rd_data, 32'h8000_0000);
    step(cur_pins, 1'b0, 3'd0, '0, 3'd5); chk("R3", rd_data, '0);
    wreg(3'd5, 32'hFFFF_FFFF); chk("R3", rd_data, '0);

    // R2 / R6: wake path
    wreg(3'd2, 32'h0000_0020);
    cur_pins[5] = 1'b1; idle(6);
    chk("R2", rd_data, 32'h20); chk("R6", 32'(wake_o), 1);
    wreg(3'd5, 32'h20); chk("R6", 32'(wake_o), 0); chk("R5", 32'(irq_o), 0);
    wreg(3'd0, 32'h0000_0040);
    cur_pins[6] = 1'b1; idle(6);
    chk("R6", 32'(wake_o), 0); chk("R5", 32'(irq_o), 1);
    wreg(3'd5, 32'h40);

    // R9: acknowledge collides with a new edge
    wreg(3'd0, 32'h80); wreg(3'd1, 32'h80);
    cur_pins[7] = 1'b1; idle(6); chk("R9", rd_data, 32'h80);
    cur_pins[7] = 1'b0; idle(2);
    wreg(3'd5, 32'h80); chk("R9", rd_data, 32'h80);
    wreg(3'd5, 32'h80); chk("R3", rd_data, '0);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      int sel;
      cur_pins = cur_pins ^ ($urandom() & $urandom() & $urandom());
      sel = $urandom_range(0, 9);
      r = $urandom();
      if (sel < 2)       step(cur_pins, 1'b1, 3'($urandom_range(0, 4)), r, 3'($urandom_range(0, 5)));
      else if (sel < 5)  step(cur_pins, 1'b1, 3'd5, r & $urandom(), 3'($urandom_range(0, 5)));
      else               step(cur_pins, 1'b0, 3'd0, '0, 3'($urandom_range(0, 5)));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule